// File: doc/BRIEF.md
# Drift-Widened Accuracy Interval with Pulse-per-Second Capture

This block keeps two error bounds around the local clock: a lower margin and an upper margin. The reference time is taken to lie between local time minus the lower margin and local time plus the upper margin. On every clock tick each margin grows by its own programmable increment, so the interval keeps covering the worst-case drift of the local oscillator. When a synchronization algorithm has new knowledge of the reference, software writes either margin directly, and the new value replaces the old one at once. Because the margins are relative to the local clock, no smoothing of the written values is needed.

An external one-pulse-per-second signal is passed through a two-stage synchronizer. Each rising edge produces one snapshot of the current local time and of both margins. The snapshot leaves the block on a valid/ready output. `cap_valid` rises with a new record, and the record stays stable until a cycle in which both `cap_valid` and `cap_ready` are high. That cycle is the acknowledge. Back-pressure is never allowed to lose the newest pulse. A pulse that arrives while the previous record is still unacknowledged overwrites it and raises `cap_overrun`.

Top module: `acc_interval_pps`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, both margins, `cap_valid`, `cap_overrun` and all three captured fields become zero.
- R2: At an edge where `tick` is high and the margin's load strobe is low, the margin becomes its old value plus its own increment. At an edge where both are low, it holds.
- R3: A margin that would exceed 2^ACC_W-1 takes the value 2^ACC_W-1 and never wraps to a smaller value.
- R4: At an edge where a margin's load strobe is high, the margin takes the load value, whatever `tick` and the increment are.
- R5: The lower and upper margins are independent. The strobe, value and increment of one never change the other.
- R6: When `pps_in` is first seen high at rising clock edge k after having been low, one capture happens at edge k+2. It records `cur_time` as presented at that edge, and both margins as they were just before that edge. A pulse held high for many cycles gives exactly one capture.
- R7: A capture sets `cap_valid`. While `cap_valid` is high and no new capture occurs, the record holds. An edge with `cap_valid` and `cap_ready` both high and no capture clears `cap_valid`.
- R8: A capture while `cap_valid` is high and `cap_ready` is low overwrites the record and sets `cap_overrun`. Any acknowledge clears `cap_overrun`. A capture coinciding with an acknowledge loads the new record with `cap_overrun` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Drift step enable |
| cur_time | input | TIME_W | Current local time |
| lo_inc | input | ACC_W | Lower margin increment per tick |
| hi_inc | input | ACC_W | Upper margin increment per tick |
| lo_ld | input | 1 | Lower margin load strobe |
| lo_ld_val | input | ACC_W | Lower margin load value |
| hi_ld | input | 1 | Upper margin load strobe |
| hi_ld_val | input | ACC_W | Upper margin load value |
| pps_in | input | 1 | Asynchronous pulse-per-second input |
| lo_bound | output | ACC_W | Live lower margin |
| hi_bound | output | ACC_W | Live upper margin |
| cap_valid | output | 1 | Capture record valid |
| cap_ready | input | 1 | Capture record accepted |
| cap_time | output | TIME_W | Captured local time |
| cap_lo | output | ACC_W | Captured lower margin |
| cap_hi | output | ACC_W | Captured upper margin |
| cap_overrun | output | 1 | A record was overwritten before acceptance |

## Verification
The bench builds the block with ACC_W=8 and TIME_W=16. With 8-bit margins, increments of up to 255 reach the saturation ceiling within a few ticks. Random stimulus therefore exercises clamping often, not only in the directed case. With a 16-bit time, captured times stay distinct across the run, so a capture taken one edge too early or too late shows up in `cap_time`.

// File: rtl/acc_pps_pkg.sv
package acc_pps_pkg;
  typedef enum logic {BND_LO = 1'b0, BND_HI = 1'b1} bnd_e;
  localparam int NUM_BND = 2;
  localparam int SYNC_N  = 2;
endpackage

// File: rtl/acc_bound.sv
module acc_bound #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] inc,
  output logic [W-1:0] bound
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W:0]   sum;
  logic [W-1:0] grown;

  always_comb begin
    sum   = {1'b0, bound} + {1'b0, inc};
    grown = sum[W] ? MAXV : sum[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     bound <= '0;
    else if (load)  bound <= ld_val;
    else if (tick)  bound <= grown;
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bound == $past(ld_val)); // R4
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load) |=> bound >= $past(bound)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(bound)); // R2
endmodule

// File: rtl/pps_edge.sv
module pps_edge
  import acc_pps_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pps_in,
  output logic rise
);
  logic [SYNC_N-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], pps_in};
      prev_q <= sync_q[SYNC_N-1];
    end
  end

  assign rise = sync_q[SYNC_N-1] & ~prev_q;

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R6
endmodule

// File: rtl/pps_capture.sv
module pps_capture #(
  parameter int TW = 64,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise,
  input  logic [TW-1:0] cur_time,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic          cap_ready,
  output logic          cap_valid,
  output logic          cap_overrun,
  output logic [TW-1:0] cap_time,
  output logic [AW-1:0] cap_lo,
  output logic [AW-1:0] cap_hi
);
  logic accept;
  assign accept = cap_valid & cap_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_valid   <= 1'b0;
      cap_overrun <= 1'b0;
      cap_time    <= '0;
      cap_lo      <= '0;
      cap_hi      <= '0;
    end else if (rise) begin
      cap_valid   <= 1'b1;
      cap_time    <= cur_time;
      cap_lo      <= lo;
      cap_hi      <= hi;
      if (cap_valid && !cap_ready) cap_overrun <= 1'b1;
      else if (accept)             cap_overrun <= 1'b0;
    end else if (accept) begin
      cap_valid   <= 1'b0;
      cap_overrun <= 1'b0;
    end
  end

  AST_OVR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cap_overrun |-> cap_valid); // R8
  AST_HOLD_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cap_ready && !rise) |=> (cap_valid && $stable(cap_time) && $stable(cap_lo))); // R7
  AST_CAPTURE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> cap_valid); // R7
endmodule

// File: rtl/acc_interval_pps.sv
module acc_interval_pps
  import acc_pps_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [TIME_W-1:0] cur_time,
  input  logic [ACC_W-1:0]  lo_inc,
  input  logic [ACC_W-1:0]  hi_inc,
  input  logic              lo_ld,
  input  logic [ACC_W-1:0]  lo_ld_val,
  input  logic              hi_ld,
  input  logic [ACC_W-1:0]  hi_ld_val,
  input  logic              pps_in,
  output logic [ACC_W-1:0]  lo_bound,
  output logic [ACC_W-1:0]  hi_bound,
  output logic              cap_valid,
  input  logic              cap_ready,
  output logic [TIME_W-1:0] cap_time,
  output logic [ACC_W-1:0]  cap_lo,
  output logic [ACC_W-1:0]  cap_hi,
  output logic              cap_overrun
);
  logic [NUM_BND-1:0]            ld_vec;
  logic [NUM_BND-1:0][ACC_W-1:0] ldv_vec;
  logic [NUM_BND-1:0][ACC_W-1:0] inc_vec;
  logic [NUM_BND-1:0][ACC_W-1:0] bnd_vec;
  logic                          pps_rise;

  always_comb begin
    ld_vec[BND_LO]  = lo_ld;
    ld_vec[BND_HI]  = hi_ld;
    ldv_vec[BND_LO] = lo_ld_val;
    ldv_vec[BND_HI] = hi_ld_val;
    inc_vec[BND_LO] = lo_inc;
    inc_vec[BND_HI] = hi_inc;
  end

  for (genvar g = 0; g < NUM_BND; g++) begin : g_bnd
    acc_bound #(.W(ACC_W)) u_bnd (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .load   (ld_vec[g]),
      .ld_val (ldv_vec[g]),
      .inc    (inc_vec[g]),
      .bound  (bnd_vec[g])
    );
  end

  assign lo_bound = bnd_vec[BND_LO];
  assign hi_bound = bnd_vec[BND_HI];

  pps_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .pps_in (pps_in),
    .rise   (pps_rise)
  );

  pps_capture #(.TW(TIME_W), .AW(ACC_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise        (pps_rise),
    .cur_time    (cur_time),
    .lo          (lo_bound),
    .hi          (hi_bound),
    .cap_ready   (cap_ready),
    .cap_valid   (cap_valid),
    .cap_overrun (cap_overrun),
    .cap_time    (cap_time),
    .cap_lo      (cap_lo),
    .cap_hi      (cap_hi)
  );

  AST_BOUNDS_INDEPENDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && lo_ld && !hi_ld) |=> $stable(hi_bound)); // R5
endmodule

// File: tb/tb_acc_interval_pps.sv
module tb_acc_interval_pps;
  localparam int TW = 16;
  localparam int AW = 8;
  localparam logic [AW-1:0] AMAX = {AW{1'b1}};

  logic clk = 1'b0;
  logic rst_n, tick, lo_ld, hi_ld, pps_in, cap_ready;
  logic [TW-1:0] cur_time;
  logic [AW-1:0] lo_inc, hi_inc, lo_ld_val, hi_ld_val;
  logic [AW-1:0] lo_bound, hi_bound, cap_lo, cap_hi;
  logic [TW-1:0] cap_time;
  logic cap_valid, cap_overrun;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  acc_interval_pps #(.TIME_W(TW), .ACC_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cur_time(cur_time),
    .lo_inc(lo_inc), .hi_inc(hi_inc), .lo_ld(lo_ld), .lo_ld_val(lo_ld_val),
    .hi_ld(hi_ld), .hi_ld_val(hi_ld_val), .pps_in(pps_in),
    .lo_bound(lo_bound), .hi_bound(hi_bound), .cap_valid(cap_valid),
    .cap_ready(cap_ready), .cap_time(cap_time), .cap_lo(cap_lo),
    .cap_hi(cap_hi), .cap_overrun(cap_overrun)
  );

  // reference model, derived from the requirements
  logic [AW-1:0] m_lo, m_hi, m_clo, m_chi;
  logic [TW-1:0] m_ct;
  logic m_v, m_ov, p1, p2, p3;

  function automatic logic [AW-1:0] grow(input logic [AW-1:0] b, input logic [AW-1:0] i);
    int unsigned s;
    s = int'(b) + int'(i);
    return (s > int'(AMAX)) ? AMAX : AW'(s);
  endfunction

  always @(posedge clk) begin
    logic cap;
    if (!rst_n) begin
      m_lo = '0; m_hi = '0; m_clo = '0; m_chi = '0; m_ct = '0;
      m_v = 1'b0; m_ov = 1'b0; p1 = 1'b0; p2 = 1'b0; p3 = 1'b0;
    end else begin
      cap = p2 & ~p3;
      if (cap) begin
        m_ov  = m_v & ~cap_ready;
        m_v   = 1'b1;
        m_ct  = cur_time;
        m_clo = m_lo;
        m_chi = m_hi;
      end else if (m_v && cap_ready) begin
        m_v  = 1'b0;
        m_ov = 1'b0;
      end
      p3 = p2; p2 = p1; p1 = pps_in;
      if (lo_ld) m_lo = lo_ld_val; else if (tick) m_lo = grow(m_lo, lo_inc);
      if (hi_ld) m_hi = hi_ld_val; else if (tick) m_hi = grow(m_hi, hi_inc);
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R5 lo_bound", 64'(lo_bound), 64'(m_lo));
    chk("R2 hi_bound", 64'(hi_bound), 64'(m_hi));
    chk("R7 cap_valid", 64'(cap_valid), 64'(m_v));
    chk("R8 cap_overrun", 64'(cap_overrun), 64'(m_ov));
    chk("R6 cap_time", 64'(cap_time), 64'(m_ct));
    chk("R6 cap_lo", 64'(cap_lo), 64'(m_clo));
    chk("R6 cap_hi", 64'(cap_hi), 64'(m_chi));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    cur_time = cur_time + 16'd1;
  endtask

  task automatic quiet();
    tick = 0; lo_ld = 0; hi_ld = 0; pps_in = 0; cap_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; quiet(); cur_time = 16'h0100;
    lo_inc = 0; hi_inc = 0; lo_ld_val = 0; hi_ld_val = 0;
    repeat (3) @(negedge clk);
    chk("R1 lo_bound reset", 64'(lo_bound), 0);
    chk("R1 hi_bound reset", 64'(hi_bound), 0);
    chk("R1 cap_valid reset", 64'(cap_valid), 0);
    chk("R1 cap_overrun reset", 64'(cap_overrun), 0);
    chk("R1 cap_time reset", 64'(cap_time), 0);
    rst_n = 1;

    // R2: growth by own increments
    lo_inc = 8'd3; hi_inc = 8'd5; tick = 1;
    repeat (4) cyc();
    chk("R2 lo after 4 ticks", 64'(lo_bound), 12);
    chk("R2 hi after 4 ticks", 64'(hi_bound), 20);
    tick = 0; cyc();
    chk("R2 hold without tick", 64'(lo_bound), 12);

    // R4: load beats tick; R5: other bound unaffected
    tick = 1; lo_ld = 1; lo_ld_val = 8'd100; cyc();
    chk("R4 load priority", 64'(lo_bound), 100);
    chk("R5 hi still grows", 64'(hi_bound), 25);
    lo_ld = 0;

    // R3: saturation
    hi_inc = 8'd200; repeat (3) cyc();
    chk("R3 hi saturated", 64'(hi_bound), 64'(AMAX));
    tick = 0;

    // R6: held pulse captures once
    pps_in = 1; repeat (12) cyc();
    chk("R6 one capture", 64'(cap_valid), 1);
    chk("R8 no overrun for held pulse", 64'(cap_overrun), 0);
    pps_in = 0; repeat (3) cyc();

    // R8: second pulse without acknowledge
    pps_in = 1; repeat (3) cyc(); pps_in = 0; repeat (3) cyc();
    chk("R8 overrun set", 64'(cap_overrun), 1);
    cap_ready = 1; cyc(); cap_ready = 0;
    chk("R7 acknowledge clears", 64'(cap_valid), 0);
    chk("R8 acknowledge clears overrun", 64'(cap_overrun), 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      tick      = ($urandom % 2) == 0;
      lo_ld     = ($urandom % 16) == 0;
      hi_ld     = ($urandom % 16) == 0;
      lo_ld_val = AW'($urandom);
      hi_ld_val = AW'($urandom);
      if (($urandom % 8) == 0) lo_inc = AW'($urandom);
      if (($urandom % 8) == 0) hi_inc = AW'($urandom);
      if (($urandom % 6) == 0) pps_in = ~pps_in;
      cap_ready = ($urandom % 3) == 0;
      cyc();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule